// File: doc/BRIEF.md
# Multi-Rail Power Sequencer with Fault Manager

This block switches a small set of supply rails on and off in a programmed order and decides what happens to each rail when it reports a fault. A power-up sequence can be started three ways: the sampled input-voltage word climbing above a programmed upper threshold, a rising edge on the run pin, or an on command written to the register port. A power-down sequence starts on an off command or when the input voltage drops below a separate lower threshold. The order is set by time alone. Each rail has its own on-delay and off-delay, counted from the sequencing event in ticks of a prescaled time base, so any rail may come up or go down before any other.

Each rail has its own fault mode. In latch mode the rail is turned off and held off until the host writes a restart. In retry mode the rail is turned off and turned back on by itself after a shared retry delay, and this repeats for as long as the fault keeps returning. In ignore mode the rail stays on and only the alert line is pulled low. A rail that shuts down on its own fault drives a shared open-drain fault wire low. Rails selected in a listen mask treat that wire, after a two-flop synchronizer, as a fault of their own, so that dependent rails on this device and on other devices shut down together. Each general-purpose output shows either its rail's power-good or the level of the shared wire.

Top module: `rail_seq`

## Requirements
- R1: After reset every rail enable is 0, alert_n is 1, flt_line_oe is 0 and every gpio_out bit is 0.
- R2: A sequence starts when the input comparison state becomes true (vin above the on threshold at address 1), when run_pin rises while that state is true, or when a command write (address 0) sets bit 0 while that state is true. No start occurs while a sequence is already on.
- R3: After a start, each rail in the off state enables once its on-delay (address 8+3*i) has elapsed in ticks of TICK_DIV clocks, so the rails come up in the order their delays give.
- R4: A command write with bit 1 set, or vin dropping below the off threshold (address 2), starts power-down. Each enabled rail turns off after its off-delay (address 9+3*i). A vin value between the two thresholds changes nothing.
- R5: Fault mode 0 (address 10+3*i): a fault on an enabled rail turns it off on the next clock, and it stays off until a command write with bit 3 set. After that write the rail comes up again after its on-delay.
- R6: Fault mode 1: a fault turns the rail off, and after the retry delay (address 3) the rail turns on again by itself. While the fault persists this repeats.
- R7: Fault modes 2 and 3: a fault leaves the rail enabled and pulls alert_n low.
- R8: alert_n stays low after any fault event until a command write with bit 2 set. If a fault event falls in the same cycle as that write, alert_n stays low.
- R9: flt_line_oe is 1 while a rail in mode 0 or 1 is off because of its own fault. A rail whose bit is set in the listen mask (address 5) treats a low flt_line_in, taken through two flops, as a fault handled by its own mode.
- R10: gpio_out bit i shows the synchronized flt_line_in level when bit i of the select register (address 4) is 1. When that bit is 0, it shows rail_pg[i] while rail i is fully on.
- R11: An off command or an input undervoltage cancels a pending retry. A rail waiting to retry turns off and does not come back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vin | input | VW | Sampled input-voltage word |
| run_pin | input | 1 | Run/control pin, synchronous to clk |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Register write data |
| rail_fault | input | NRAIL | Per-rail fault flags |
| rail_pg | input | NRAIL | Per-rail power-good flags |
| flt_line_in | input | 1 | Level of the shared fault wire (low = fault) |
| flt_line_oe | output | 1 | Pull the shared fault wire low |
| rail_en | output | NRAIL | Per-rail enables |
| alert_n | output | 1 | Active-low sticky alert |
| gpio_out | output | NRAIL | Per-rail power-good or fault-wire status |

## Verification
The pair of events that can share a cycle is a clear-faults write and a new fault event. The bench drives a one-cycle fault on an ignore-mode rail in the same cycle as the clear write. It expects alert_n to stay low, and to go high only after a later clear write with no fault beside it. A second case puts an off command inside a pending retry window. There the bench requires the rail to stay off well past the time the retry would have ended.

// File: rtl/rail_seq.sv
module rail_seq #(
  parameter int NRAIL    = 3,
  parameter int VW       = 12,
  parameter int DW       = 16,
  parameter int AW       = 6,
  parameter int TICK_DIV = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VW-1:0]    vin,
  input  logic             run_pin,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  input  logic [NRAIL-1:0] rail_fault,
  input  logic [NRAIL-1:0] rail_pg,
  input  logic             flt_line_in,
  output logic             flt_line_oe,
  output logic [NRAIL-1:0] rail_en,
  output logic             alert_n,
  output logic [NRAIL-1:0] gpio_out
);
  localparam int TW = $clog2(TICK_DIV);
  localparam logic [2:0] S_OFF = 3'd0, S_WON = 3'd1, S_ON = 3'd2,
                         S_WOFF = 3'd3, S_LAT = 3'd4, S_RTY = 3'd5;

  logic [NRAIL-1:0][2:0]    st;
  logic [NRAIL-1:0][DW-1:0] cnt, on_dly, off_dly;
  logic [NRAIL-1:0][1:0]    mode;
  logic [NRAIL-1:0]         own, listen, gsel, hit, ev;
  logic [DW-1:0]            retry_dly;
  logic [VW-1:0]            th_on, th_off;
  logic [TW-1:0]            pre;
  logic vin_ok, vin_ok_d, run_d, seq_on, ls1, ls2, alert_q;

  wire cmd       = reg_we && reg_addr == '0;
  wire c_on      = cmd & reg_wdata[0];
  wire c_off     = cmd & reg_wdata[1];
  wire c_clr     = cmd & reg_wdata[2];
  wire c_rst     = cmd & reg_wdata[3];
  wire tick      = pre == TW'(TICK_DIV - 1);
  wire start_evt = ~seq_on & vin_ok & ((vin_ok & ~vin_ok_d) | (run_pin & ~run_d) | c_on);
  wire stop_evt  = seq_on & (c_off | ~vin_ok);
  wire live      = (seq_on & ~stop_evt) | start_evt;

  assign flt_line_oe = |own;
  assign alert_n     = ~alert_q;

  always_comb begin
    for (int i = 0; i < NRAIL; i++) begin
      hit[i]      = rail_fault[i] | (listen[i] & ~ls2);
      ev[i]       = (st[i] == S_ON) & hit[i];
      rail_en[i]  = (st[i] == S_ON) | (st[i] == S_WOFF);
      gpio_out[i] = gsel[i] ? ls2 : (rail_pg[i] & (st[i] == S_ON));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0; vin_ok <= 1'b0; vin_ok_d <= 1'b0; run_d <= 1'b0;
      seq_on <= 1'b0; ls1 <= 1'b1; ls2 <= 1'b1; alert_q <= 1'b0;
      th_on <= '1; th_off <= '0; retry_dly <= '0;
      listen <= '0; gsel <= '0; own <= '0;
      st <= '0; cnt <= '0; on_dly <= '0; off_dly <= '0; mode <= '0;
    end else begin
      pre      <= (tick | start_evt | stop_evt) ? '0 : pre + 1'b1;
      vin_ok   <= (vin > th_on) ? 1'b1 : (vin < th_off) ? 1'b0 : vin_ok;
      vin_ok_d <= vin_ok;
      run_d    <= run_pin;
      ls1      <= flt_line_in;
      ls2      <= ls1;
      if (stop_evt)       seq_on <= 1'b0;
      else if (start_evt) seq_on <= 1'b1;
      if (|ev)            alert_q <= 1'b1;
      else if (c_clr)     alert_q <= 1'b0;
      if (reg_we) begin
        if (reg_addr == AW'(1)) th_on     <= reg_wdata[VW-1:0];
        if (reg_addr == AW'(2)) th_off    <= reg_wdata[VW-1:0];
        if (reg_addr == AW'(3)) retry_dly <= reg_wdata;
        if (reg_addr == AW'(4)) gsel      <= reg_wdata[NRAIL-1:0];
        if (reg_addr == AW'(5)) listen    <= reg_wdata[NRAIL-1:0];
      end
      for (int i = 0; i < NRAIL; i++) begin
        if (reg_we && reg_addr == AW'(8 + 3*i))  on_dly[i]  <= reg_wdata;
        if (reg_we && reg_addr == AW'(9 + 3*i))  off_dly[i] <= reg_wdata;
        if (reg_we && reg_addr == AW'(10 + 3*i)) mode[i]    <= reg_wdata[1:0];
        case (st[i])
          S_OFF: if (start_evt) begin st[i] <= S_WON; cnt[i] <= on_dly[i]; end
          S_WON: begin
            if (stop_evt)           st[i] <= S_OFF;
            else if (cnt[i] == '0)  st[i] <= S_ON;
            else if (tick)          cnt[i] <= cnt[i] - 1'b1;
          end
          S_ON: begin
            if (stop_evt) begin
              st[i] <= S_WOFF; cnt[i] <= off_dly[i];
            end else if (hit[i] && !mode[i][1]) begin
              own[i] <= rail_fault[i];
              if (mode[i][0]) begin st[i] <= S_RTY; cnt[i] <= retry_dly; end
              else st[i] <= S_LAT;
            end
          end
          S_WOFF: begin
            if (start_evt) begin st[i] <= S_WON; cnt[i] <= on_dly[i]; end
            else if (cnt[i] == '0) st[i] <= S_OFF;
            else if (tick)         cnt[i] <= cnt[i] - 1'b1;
          end
          S_LAT: if (c_rst) begin
            own[i] <= 1'b0;
            if (live) begin st[i] <= S_WON; cnt[i] <= on_dly[i]; end
            else st[i] <= S_OFF;
          end
          S_RTY: begin
            if (stop_evt)          begin st[i] <= S_OFF; own[i] <= 1'b0; end
            else if (cnt[i] == '0) begin st[i] <= S_ON;  own[i] <= 1'b0; end
            else if (tick)         cnt[i] <= cnt[i] - 1'b1;
          end
          default: st[i] <= S_OFF;
        endcase
      end
    end
  end
endmodule

// File: rtl/rail_seq_chk.sv
module rail_seq_chk #(
  parameter int NRAIL = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NRAIL-1:0][2:0] st,
  input logic [NRAIL-1:0][1:0] mode,
  input logic [NRAIL-1:0]      rail_en,
  input logic [NRAIL-1:0]      rail_fault,
  input logic                  alert_n,
  input logic                  flt_line_oe,
  input logic                  c_off,
  input logic                  c_clr,
  input logic                  c_rst
);
  localparam logic [2:0] S_WON = 3'd1, S_ON = 3'd2, S_LAT = 3'd4, S_RTY = 3'd5;

  logic [NRAIL-1:0] in_rty, in_flt;
  always_comb begin
    for (int i = 0; i < NRAIL; i++) begin
      in_rty[i] = st[i] == S_RTY;
      in_flt[i] = (st[i] == S_RTY) | (st[i] == S_LAT);
    end
  end

  a_r8_alert_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!alert_n && !c_clr) |=> !alert_n);

  a_r9_line_from_fault: assert property (@(posedge clk) disable iff (!rst_n)
    flt_line_oe |-> (in_flt != '0));

  a_r11_off_cancels_retry: assert property (@(posedge clk) disable iff (!rst_n)
    c_off |=> (in_rty == '0));

  for (genvar i = 0; i < NRAIL; i++) begin : g_rail
    a_r5_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st[i] == S_LAT && !c_rst) |=> (st[i] == S_LAT && !rail_en[i]));

    a_r7_ignore_keeps_on: assert property (@(posedge clk) disable iff (!rst_n)
      (st[i] == S_ON && mode[i][1] && rail_fault[i]) |=> rail_en[i]);

    a_r3_rise_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rail_en[i]) |-> ($past(st[i]) == S_WON || $past(st[i]) == S_RTY));
  end
endmodule

bind rail_seq rail_seq_chk #(.NRAIL(NRAIL)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .mode(mode), .rail_en(rail_en),
  .rail_fault(rail_fault), .alert_n(alert_n), .flt_line_oe(flt_line_oe),
  .c_off(c_off), .c_clr(c_clr), .c_rst(c_rst)
);

// File: tb/tb_rail_seq.sv
module tb_rail_seq;
  localparam int N = 3;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, run_pin, reg_we, flt_line_in, flt_line_oe, alert_n;
  logic [11:0] vin;
  logic [5:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [N-1:0] rail_fault, rail_pg, rail_en, gpio_out;

  assign rail_pg     = rail_en;
  assign flt_line_in = ~flt_line_oe;

  rail_seq #(.TICK_DIV(4)) dut (
    .clk(clk), .rst_n(rst_n), .vin(vin), .run_pin(run_pin),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rail_fault(rail_fault), .rail_pg(rail_pg), .flt_line_in(flt_line_in),
    .flt_line_oe(flt_line_oe), .rail_en(rail_en), .alert_n(alert_n),
    .gpio_out(gpio_out)
  );

  typedef struct { int at; int sig; logic [N-1:0] val; string tag; } item_t;
  item_t sbq[$];
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [N-1:0] pick(int s);
    case (s)
      0: return rail_en;
      1: return {{(N-1){1'b0}}, alert_n};
      2: return {{(N-1){1'b0}}, flt_line_oe};
      default: return gpio_out;
    endcase
  endfunction

  task automatic expect_at(int dt, int sig, logic [N-1:0] v, string tag);
    item_t it;
    int k = 0;
    it.at = cyc + dt; it.sig = sig; it.val = v; it.tag = tag;
    while (k < sbq.size() && sbq[k].at <= it.at) k++;
    sbq.insert(k, it);
  endtask

  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].at <= cyc) begin
      item_t it;
      it = sbq.pop_front();
      total++;
      if (pick(it.sig) !== it.val) begin
        bad++;
        $display("FAIL %s sig%0d act=%b exp=%b", it.tag, it.sig, pick(it.sig), it.val);
      end
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s act=%0d exp=%0d", tag, act, exp); end
  endtask

  task automatic step(int n); repeat (n) @(negedge clk); endtask

  task automatic wr(int a, int d);
    @(negedge clk); reg_we = 1; reg_addr = 6'(a); reg_wdata = 16'(d);
    @(negedge clk); reg_we = 0;
  endtask

  initial begin
    rst_n = 0; run_pin = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    vin = 0; rail_fault = 0;
    step(3); rst_n = 1;
    expect_at(1, 0, 3'b000, "R1 en");
    expect_at(1, 1, 3'b001, "R1 alert");
    expect_at(1, 2, 3'b000, "R1 line");
    expect_at(1, 3, 3'b000, "R1 gpio");
    step(2);
    wr(1, 100); wr(2, 50); wr(3, 5);
    wr(8, 2);  wr(9, 8);  wr(10, 1);
    wr(11, 10); wr(12, 1); wr(13, 0);
    wr(14, 6); wr(15, 4); wr(16, 2);
    step(5);
    expect_at(1, 0, 3'b000, "R2 no start before vin");

    // R2 vin trigger, R3 order
    vin = 200;
    expect_at(15, 0, 3'b001, "R3 first rail");
    expect_at(35, 0, 3'b101, "R3 second rail");
    expect_at(50, 0, 3'b111, "R2 vin start all on");
    step(55);

    // R4 off command
    wr(0, 2);
    expect_at(10, 0, 3'b101, "R4 first off");
    expect_at(25, 0, 3'b001, "R4 second off");
    expect_at(40, 0, 3'b000, "R4 all off");
    step(45);

    // R2 run pin trigger
    run_pin = 1;
    expect_at(14, 0, 3'b001, "R2 run first");
    expect_at(48, 0, 3'b111, "R2 run all on");
    step(52);

    // R6 retry, R8 alert
    rail_fault[0] = 1;
    expect_at(2, 0, 3'b110, "R6 retry off");
    expect_at(2, 1, 3'b000, "R8 alert set");
    step(1); rail_fault[0] = 0;
    expect_at(11, 0, 3'b110, "R6 still waiting");
    expect_at(29, 0, 3'b111, "R6 retried on");
    step(35);
    begin
      int rises = 0;
      logic prev = rail_en[0];
      rail_fault[0] = 1;
      for (int k = 0; k < 120; k++) begin
        step(1);
        if (rail_en[0] && !prev) rises++;
        prev = rail_en[0];
      end
      rail_fault[0] = 0;
      check(rises >= 3, "R6 hiccup repeats", rises, 3);
    end
    step(40);
    expect_at(1, 0, 3'b111, "R6 recovered");
    expect_at(1, 1, 3'b000, "R8 alert held");
    step(2);
    wr(0, 4);
    expect_at(2, 1, 3'b001, "R8 clear");
    step(3);

    // R7 ignore
    rail_fault[2] = 1;
    expect_at(3, 0, 3'b111, "R7 rail kept on");
    expect_at(3, 1, 3'b000, "R7 alert low");
    step(4); rail_fault[2] = 0;
    wr(0, 4);
    expect_at(2, 1, 3'b001, "R8 clear after ignore");
    step(3);
    // R8 same cycle clear and fault
    @(negedge clk); reg_we = 1; reg_addr = 0; reg_wdata = 4; rail_fault[2] = 1;
    @(negedge clk); reg_we = 0; rail_fault[2] = 0;
    expect_at(2, 1, 3'b000, "R8 set wins over clear");
    step(3);
    wr(0, 4);
    expect_at(2, 1, 3'b001, "R8 lone clear");
    step(3);

    // R5 latch
    rail_fault[1] = 1;
    expect_at(2, 0, 3'b101, "R5 latched off");
    expect_at(60, 0, 3'b101, "R5 stays off");
    step(1); rail_fault[1] = 0;
    step(62);
    wr(0, 8);
    expect_at(20, 0, 3'b101, "R5 restart waits on-delay");
    expect_at(55, 0, 3'b111, "R5 restart on");
    step(58);
    wr(0, 4);

    // R9 propagation, R10 gpio select
    wr(5, 6); wr(4, 1);
    step(2);
    rail_fault[0] = 1;
    expect_at(2, 2, 3'b001, "R9 line driven");
    expect_at(6, 0, 3'b100, "R9 listener latched");
    expect_at(6, 3, 3'b100, "R10 gpio line low");
    step(1); rail_fault[0] = 0;
    expect_at(35, 0, 3'b101, "R9 source back, listener held");
    expect_at(35, 2, 3'b000, "R9 line released");
    expect_at(35, 3, 3'b101, "R10 gpio mix");
    step(38);
    wr(5, 0); wr(4, 0); wr(0, 4); wr(0, 8);
    step(50);
    expect_at(1, 0, 3'b111, "R5 all back");
    step(2);

    // R11 off cancels retry
    rail_fault[0] = 1;
    step(1); rail_fault[0] = 0;
    wr(0, 2);
    expect_at(40, 0, 3'b000, "R11 no retry");
    expect_at(60, 0, 3'b000, "R11 still off");
    step(62);

    // R2 on command, R4 hysteresis and undervoltage
    wr(0, 1);
    expect_at(45, 0, 3'b111, "R2 on command");
    step(48);
    vin = 70;
    expect_at(20, 0, 3'b111, "R4 hysteresis band");
    step(22);
    vin = 30;
    expect_at(12, 0, 3'b101, "R4 uv first off");
    expect_at(25, 0, 3'b001, "R4 uv second off");
    expect_at(45, 0, 3'b000, "R4 uv all off");
    step(48);

    while (sbq.size() > 0) step(1);
    step(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule